// File: doc/BRIEF.md
# Buffered UART Baud Rate Generator

This block generates the timing strobes for an asynchronous serial port. Software programs a 13-bit modulo divisor through two byte-wide registers. The block produces a one-cycle oversampling pulse every divisor clocks. It also produces a one-cycle bit pulse on every sixteenth oversampling pulse, so the bit rate is the module clock divided by sixteen times the divisor. The transmitter and receiver shifters consume these strobes, and they sit outside this block.

The divisor is split between an upper register and a lower register. A write to the upper register only fills a holding buffer. The value in use changes when the lower register is written, and both halves then take effect together. The counters run only when the divisor is non-zero and at least one of the receive or transmit enables is high. They restart from zero whenever the divisor is committed or the generator is stopped. The upper register also holds two interrupt-enable flags, which this block only stores and returns on reads.

Top module: `uart_rate_gen`

## Requirements
- R1: Register select 0 is the upper register, whose bits 4..0 carry divisor bits 12..8. Register select 1 is the lower register, which carries divisor bits 7..0. The working divisor D is {upper[4:0], lower[7:0]}.
- R2: A write to the upper register leaves the working divisor, and the divisor bits read back from either register, unchanged. A later write to the lower register commits the buffered upper bits and the new lower byte in the same clock.
- R3: With D in 1..8191 and the generator running, `ovs_tick` is a one-cycle pulse every D clocks. The first pulse is visible in the D-th cycle after the clock edge at which the generator starts.
- R4: `bit_tick` is a one-cycle pulse in the cycle after every sixteenth `ovs_tick` pulse. This makes its first pulse visible in cycle 16*D+1 after start, and its period 16*D.
- R5: When D is 0, neither `ovs_tick` nor `bit_tick` ever pulses.
- R6: After reset the upper register reads 0x00, the lower register reads 0x04, and both strobes are low.
- R7: No strobe pulses while `rx_en` and `tx_en` are both low, including the idle time after reset. Either enable alone starts the generator. Stopping and restarting gives a full-length first period.
- R8: Upper register bit 7 (break interrupt enable) and bit 6 (edge interrupt enable) are stored at the upper write itself and read back at once. Bit 5 always reads 0.
- R9: Every write to the lower register restarts both counters, even when the value written is unchanged. The first `ovs_tick` after the write is visible D cycles after the cycle following the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 upper, 1 lower |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| ovs_tick | output | 1 | Oversampling strobe, one pulse per D clocks |
| bit_tick | output | 1 | Bit strobe, one pulse per 16 oversampling pulses |

## Verification
The bench aims at the two-step divisor update. It writes only the upper register and confirms that the tick period and the readback stay on the old value. A design that committed the upper byte early would jump to a wrong rate between the two writes. It rewrites the lower register with an unchanged value in the middle of a count and measures a full first period. A design that restarted only on a changed value would emit a short tick there. The bench also covers divisor 0, divisor 1, and a stop and restart in the middle of a period. It checks that bit 5 reads as zero while the interrupt-enable bits take effect at once. Each of these edges exposes an off-by-one count or a missing gate in the clearing logic.

// File: rtl/uart_rate_pkg.sv
// Package: shared constants for the UART rate generator.
// Assumes an 8-bit register bus and a divisor of at most 14 bits, so
// that upper-register bits 7 and 6 stay free for the enable flags.
package uart_rate_pkg;

    localparam int REG_W = 8;

    // Register select codes; the lower register commits the divisor.
    typedef enum logic [0:0] {
        SEL_UPPER = 1'b0,
        SEL_LOWER = 1'b1
    } reg_sel_e;

    localparam int UP_BRK_IE_BIT  = 7;
    localparam int UP_EDGE_IE_BIT = 6;

endpackage

// File: rtl/uart_rate_regs.sv
// Module: register pair holding the divisor and two interrupt-enable flags.
// Upper writes fill a holding buffer, and the flags take effect at once.
// A lower write commits {buffer, lower byte} and raises commit_o in the
// same cycle, combinationally, so that the counters restart at that edge.
// Assumes DIV_W is between 9 and 14.
module uart_rate_regs
    import uart_rate_pkg::*;
#(
    parameter int DIV_W   = 13,
    parameter int RST_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [DIV_W-1:0]     div_o,
    output logic                 commit_o
);

    localparam int UP_W = DIV_W - REG_W;
    localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

    logic [UP_W-1:0]  up_hold;
    logic [DIV_W-1:0] div_q;
    logic             brk_ie_q;
    logic             edge_ie_q;
    logic             wr_up;
    logic             wr_lo;
    logic [REG_W-1:0] up_view;

    // Decode the two write strobes.
    always_comb begin
        wr_up = wr_en && (addr == SEL_UPPER);
        wr_lo = wr_en && (addr == SEL_LOWER);
    end

    // Holding buffer and flags: loaded by upper-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_hold   <= RST_VAL[DIV_W-1:REG_W];
            brk_ie_q  <= 1'b0;
            edge_ie_q <= 1'b0;
        end else if (wr_up) begin
            up_hold   <= wr_data[UP_W-1:0];
            brk_ie_q  <= wr_data[UP_BRK_IE_BIT];
            edge_ie_q <= wr_data[UP_EDGE_IE_BIT];
        end
    end

    // Working divisor: both halves change only on a lower-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= RST_VAL;
        end else if (wr_lo) begin
            div_q <= {up_hold, wr_data};
        end
    end

    // Upper readback: flags, zero padding, working upper divisor bits.
    always_comb begin
        up_view                 = '0;
        up_view[UP_W-1:0]       = div_q[DIV_W-1:REG_W];
        up_view[UP_BRK_IE_BIT]  = brk_ie_q;
        up_view[UP_EDGE_IE_BIT] = edge_ie_q;
    end

    // Read mux over the two registers.
    always_comb begin
        if (addr == SEL_UPPER) begin
            rd_data = up_view;
        end else begin
            rd_data = div_q[REG_W-1:0];
        end
    end

    assign div_o    = div_q;
    assign commit_o = wr_lo;

endmodule

// File: rtl/uart_rate_prescale.sv
// Module: modulo-D prescaler that emits the oversampling strobe.
// Counts 0..div_i-1 while run_i is high and emits a registered one-cycle
// pulse on the last count. clear_i forces count and pulse to zero.
// Assumes div_i is non-zero whenever run_i is high.
module uart_rate_prescale #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] cnt_o,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;
    logic             last;

    // Terminal-count detect for the current divisor.
    always_comb begin
        last = (cnt_q == (div_i - ONE));
    end

    // Count and pulse register; held cleared while stopped or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (clear_i || !run_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (last) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + ONE;
            tick_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign tick_o = tick_q;

endmodule

// File: rtl/uart_rate_ovsdiv.sv
// Module: divides the oversampling strobe by RATIO to form the bit strobe.
// Emits a registered pulse the cycle after every RATIO-th input pulse.
// Assumes RATIO is at least 2.
module uart_rate_ovsdiv #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    input  logic ovs_i,
    output logic bit_o
);

    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          bit_q;

    // Count oversampling pulses; wrap and pulse on the RATIO-th one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= 1'b0;
        end else if (clear_i || !run_i) begin
            cnt_q <= '0;
            bit_q <= 1'b0;
        end else if (ovs_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                bit_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + ONE;
                bit_q <= 1'b0;
            end
        end else begin
            bit_q <= 1'b0;
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/uart_rate_gen.sv
// Module: top of the UART rate generator.
// Joins the register pair, the run gate, the prescaler and the
// oversample divider. The generator runs when either enable is high and
// the divisor is non-zero; otherwise both counters are held at zero.
// Assumes a single clock domain and synchronous enables.
module uart_rate_gen
    import uart_rate_pkg::*;
#(
    parameter int DIV_W     = 13,
    parameter int OVS_RATIO = 16,
    parameter int RST_DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             rx_en,
    input  logic             tx_en,
    output logic             ovs_tick,
    output logic             bit_tick
);

    logic [DIV_W-1:0] div_work;
    logic [DIV_W-1:0] pre_cnt;
    logic             commit;
    logic             run;

    uart_rate_regs #(
        .DIV_W   (DIV_W),
        .RST_DIV (RST_DIV)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .div_o    (div_work),
        .commit_o (commit)
    );

    // Run gate: any enable and a non-zero divisor.
    always_comb begin
        run = (rx_en || tx_en) && (div_work != '0);
    end

    uart_rate_prescale #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clear_i (commit),
        .div_i   (div_work),
        .cnt_o   (pre_cnt),
        .tick_o  (ovs_tick)
    );

    uart_rate_ovsdiv #(
        .RATIO (OVS_RATIO)
    ) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clear_i (commit),
        .ovs_i   (ovs_tick),
        .bit_o   (bit_tick)
    );

endmodule

// File: rtl/uart_rate_chk.sv
// Module: protocol checker for uart_rate_gen, attached with bind.
module uart_rate_chk #(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             addr,
    input logic             rx_en,
    input logic             tx_en,
    input logic [DIV_W-1:0] div_work,
    input logic [DIV_W-1:0] pre_cnt,
    input logic             ovs_tick,
    input logic             bit_tick
);

    // R7
    off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en || tx_en) |=> (!ovs_tick && !bit_tick));

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_work == '0) |=> !ovs_tick);

    // R4
    bit_follows_ovs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(ovs_tick));

    // R2
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> $stable(div_work));

    // R9
    commit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr) |=> (!ovs_tick && pre_cnt == '0));

    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_work != '0) |-> (pre_cnt < div_work));

endmodule

bind uart_rate_gen uart_rate_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .div_work (div_work),
    .pre_cnt  (pre_cnt),
    .ovs_tick (ovs_tick),
    .bit_tick (bit_tick)
);

// File: tb/sim_uart_rate_gen.sv
// Bench for uart_rate_gen: vector table, then directed corner cases.
module sim_uart_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rx_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       ovs_tick;
    logic       bit_tick;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    uart_rate_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rx_en(rx_en),
        .tx_en(tx_en), .ovs_tick(ovs_tick), .bit_tick(bit_tick)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Vector: upper[31:24], lower[23:16], expected first-tick latency [15:0].
    localparam logic [31:0] VEC [6] = '{
        {8'h00, 8'h01, 16'd1},
        {8'h00, 8'h02, 16'd2},
        {8'h00, 8'h07, 16'd7},
        {8'hE0, 8'h05, 16'd5},
        {8'h01, 8'h03, 16'd259},
        {8'h00, 8'h00, 16'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // Count negedges until ovs_tick is seen; 0 when none within lim.
    task automatic wait_ovs(input int lim, output int k);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovs_tick && n < lim);
        k = ovs_tick ? n : 0;
    endtask

    task automatic wait_bit(input int lim, output int k);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < lim);
        k = bit_tick ? n : 0;
    endtask

    // Count strobe pulses over a window of cycles.
    task automatic count_ticks(input int len, output int no, output int nb);
        no = 0; nb = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (ovs_tick) no++;
            if (bit_tick) nb++;
        end
    endtask

    initial begin
        int v, k, no, nb, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        rd(1'b0, v); check("R6 upper reset", v, 8'h00);
        rd(1'b1, v); check("R6 lower reset", v, 8'h04);
        check("R6 strobes low", int'({ovs_tick, bit_tick}), 0);

        // R7 idle until an enable rises
        count_ticks(40, no, nb);
        check("R7 idle after reset", no + nb, 0);

        // R3 default divisor, receive enable alone
        @(negedge clk); rx_en = 1'b1;
        wait_ovs(50, k); check("R3 first tick default D=4", k, 4);
        wait_ovs(50, k); check("R3 period default D=4", k, 4);

        // Vector table: R1 layout, R3 rate, R4 bit strobe, R5 zero
        foreach (VEC[i]) begin
            @(negedge clk); rx_en = 1'b0; tx_en = 1'b0;
            wr(1'b0, VEC[i][31:24]);
            wr(1'b1, VEC[i][23:16]);
            d = int'(VEC[i][15:0]);
            rd(1'b1, v); check("R1 lower readback", v, int'(VEC[i][23:16]));
            rd(1'b0, v); check("R1 upper readback", v, int'(VEC[i][31:24]) & 8'hDF);
            tx_en = 1'b1;
            if (d == 0) begin
                count_ticks(200, no, nb);
                check("R5 zero divisor no strobes", no + nb, 0);
            end else begin
                wait_ovs(d + 10, k); check("R3 first ovs latency", k, d);
                wait_ovs(d + 10, k); check("R3 ovs period", k, d);
                if (d < 10) begin
                    @(negedge clk); tx_en = 1'b0;
                    @(negedge clk); tx_en = 1'b1;
                    wait_bit(16 * d + 20, k); check("R4 first bit latency", k, 16 * d + 1);
                    wait_bit(16 * d + 20, k); check("R4 bit period", k, 16 * d);
                end
            end
        end

        // R2 buffered upper write does not disturb the running rate
        @(negedge clk); rx_en = 1'b0; tx_en = 1'b0;
        wr(1'b0, 8'h00); wr(1'b1, 8'h03);
        tx_en = 1'b1;
        wait_ovs(20, k); check("R3 D=3 transmit only", k, 3);
        wr(1'b0, 8'h01);
        rd(1'b0, v); check("R2 upper readback holds", v, 8'h00);
        wait_ovs(20, k);
        wait_ovs(20, k); check("R2 period holds after upper write", k, 3);
        wr(1'b1, 8'h02);
        wait_ovs(400, k); check("R9 first tick after commit D=258", k, 258);
        rd(1'b0, v); check("R2 upper after commit", v, 8'h01);
        rd(1'b1, v); check("R2 lower after commit", v, 8'h02);

        // R9 rewrite of the same value mid-count restarts the period
        wr(1'b0, 8'h00); wr(1'b1, 8'h05);
        wait_ovs(20, k);
        repeat (2) @(negedge clk);
        wr(1'b1, 8'h05);
        wait_ovs(20, k); check("R9 same-value rewrite restarts", k, 5);

        // R7 stop mid-period, then restart with full period
        repeat (2) @(negedge clk);
        tx_en = 1'b0;
        count_ticks(30, no, nb); check("R7 stopped no strobes", no + nb, 0);
        rx_en = 1'b1;
        wait_ovs(20, k); check("R7 full period after restart", k, 5);

        // R8 flags immediate, bit 5 reads 0, divisor still buffered
        wr(1'b0, 8'hFF);
        rd(1'b0, v); check("R8 flags immediate", v, 8'hC0);
        wr(1'b1, 8'h10);
        rd(1'b0, v); check("R8 bit 5 reads zero", v, 8'hDF);
        wait_ovs(9000, k); check("R1 full-width divisor 0x1F10", k, 16'h1F10);
        wr(1'b0, 8'h3F);
        rd(1'b0, v); check("R8 flags cleared", v, 8'h1F);

        // R5 zero divisor while enabled
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        count_ticks(100, no, nb); check("R5 zero divisor while enabled", no + nb, 0);

        // R6 reset again restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; rx_en = 1'b0;
        rd(1'b1, v); check("R6 lower after second reset", v, 8'h04);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule